// File: doc/BRIEF.md
# Floppy Write Precompensation Shifter

This block places each serial write-data pulse for a floppy disk at one of three instants: early, nominal or late. A strobe input starts a fixed four-phase sequence on a fast clock. Each phase is one clock period long. The single output pulse is issued in the phase chosen by two shift-select inputs. The block clears the strobe at the start of the last phase, so the next pulse can be queued.

Precompensation is only active when the head is on the inner tracks and double-density recording is enabled. In every other case the block is a plain wire from write data in to write data out. With a 5 MHz phase clock, one phase equals the intended 200 ns shift.

Top module: `wprecomp_shifter`

## Requirements
- R1: After a synchronous reset with precompensation enabled, the sequence is idle. `wd_out` and `stb_clr` are both low until a strobe is taken.
- R2: With neither select asserted, the pulse on `wd_out` is high during phase 2. That is the second clock period after the edge that samples the strobe.
- R3: With only `sel_early` asserted, the pulse is high during phase 1, the first period after the strobe is sampled.
- R4: With only `sel_late` asserted, the pulse is high during phase 3, the third period after the strobe is sampled.
- R5: With both selects asserted, the request is treated as nominal and the pulse falls in phase 2.
- R6: `stb_clr` is high for exactly phase 4, the fourth period after the strobe is sampled, and is low at all other times.
- R7: When `inner_trk` is 0 or `dden_n` is 1, `wd_out` follows `wd_in` combinationally. `stb_clr` stays low and any running sequence returns to idle.
- R8: While enabled, `wd_out` is high for exactly one period per strobe and low otherwise, including in the idle phase 0.
- R9: A strobe is taken only in idle. A strobe held high during phases 1 to 4 does not restart or stretch the sequence. It starts a new one at the first edge back in idle.
- R10: The selects are captured at the edge that takes the strobe. Changing them during phases 1 to 4 does not move the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Phase clock, one period per phase |
| rst | input | 1 | Synchronous active-high reset |
| wd_in | input | 1 | Write data in, passed through when bypassed |
| wd_stb | input | 1 | Strobe that starts a pulse sequence |
| sel_early | input | 1 | Request an early pulse |
| sel_late | input | 1 | Request a late pulse |
| inner_trk | input | 1 | High when the head is on an inner track |
| dden_n | input | 1 | Active-low double-density enable |
| wd_out | output | 1 | Shifted write pulse, or `wd_in` when bypassed |
| stb_clr | output | 1 | Clears the strobe during phase 4 |

## Verification
The strobe is sampled at edge k. The early pulse is then due in the period after edge k, the nominal pulse after edge k+1, the late pulse after edge k+2, and the strobe clear after edge k+3. The bypass path has no register, so `wd_out` must equal `wd_in` in the same period. The bench changes inputs at the falling edge and advances a behavioural phase count at the rising edge. It then compares both outputs one time unit after each falling edge, when both the registered phase and the combinational bypass have settled for that period.

// File: rtl/wpc_pkg.sv
package wpc_pkg;

    localparam int unsigned NUM_PHASES = 4;
    localparam int unsigned PH_W       = $clog2(NUM_PHASES + 1);

    typedef enum logic [PH_W-1:0] {
        PH_IDLE = 3'd0,
        PH_1    = 3'd1,
        PH_2    = 3'd2,
        PH_3    = 3'd3,
        PH_4    = 3'd4
    } phase_e;

    typedef enum logic [1:0] {
        SH_NOM   = 2'd0,
        SH_EARLY = 2'd1,
        SH_LATE  = 2'd2
    } shift_e;

    typedef struct packed {
        logic early;
        logic late;
    } sel_t;

    // Conflicting requests collapse to nominal.
    function automatic shift_e decode_shift(sel_t s);
        if (s.early && !s.late)      return SH_EARLY;
        else if (s.late && !s.early) return SH_LATE;
        else                         return SH_NOM;
    endfunction

    function automatic phase_e slot_of(shift_e sh);
        case (sh)
            SH_EARLY: return PH_1;
            SH_LATE:  return PH_3;
            default:  return PH_2;
        endcase
    endfunction

    function automatic phase_e next_phase(phase_e p);
        case (p)
            PH_1:    return PH_2;
            PH_2:    return PH_3;
            PH_3:    return PH_4;
            default: return PH_IDLE;
        endcase
    endfunction

endpackage

// File: rtl/wpc_phase_ctr.sv
module wpc_phase_ctr
    import wpc_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   enable,
    input  logic   strobe,
    output phase_e phase,
    output logic   start
);

    assign start = enable && strobe && (phase == PH_IDLE);

    always_ff @(posedge clk) begin
        if (rst || !enable)          phase <= PH_IDLE;
        else if (start)              phase <= PH_1;
        else if (phase != PH_IDLE)   phase <= next_phase(phase);
    end

    // R9
    no_restart_chk: assert property (@(posedge clk) disable iff (rst)
        (phase != PH_IDLE) |=> (phase != PH_1));

    // R6
    last_phase_once_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_4) |=> (phase == PH_IDLE));

endmodule

// File: rtl/wpc_sel_hold.sv
module wpc_sel_hold
    import wpc_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   start,
    input  sel_t   sel_in,
    output shift_e shift_q
);

    always_ff @(posedge clk) begin
        if (rst)        shift_q <= SH_NOM;
        else if (start) shift_q <= decode_shift(sel_in);
    end

    // R10
    sel_held_chk: assert property (@(posedge clk) disable iff (rst)
        !start |=> $stable(shift_q));

endmodule

// File: rtl/wpc_out_stage.sv
module wpc_out_stage
    import wpc_pkg::*;
(
    input  logic   enable,
    input  phase_e phase,
    input  shift_e shift_q,
    input  logic   wd_in,
    output logic   wd_out,
    output logic   stb_clr
);

    always_comb begin
        if (enable) begin
            wd_out  = (phase == slot_of(shift_q));
            stb_clr = (phase == PH_4);
        end else begin
            wd_out  = wd_in;
            stb_clr = 1'b0;
        end
    end

endmodule

// File: rtl/wprecomp_shifter.sv
module wprecomp_shifter
    import wpc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic wd_in,
    input  logic wd_stb,
    input  logic sel_early,
    input  logic sel_late,
    input  logic inner_trk,
    input  logic dden_n,
    output logic wd_out,
    output logic stb_clr
);

    logic   pc_en;
    logic   start;
    phase_e phase;
    shift_e shift_q;
    sel_t   sel;

    assign pc_en     = inner_trk && !dden_n;
    assign sel.early = sel_early;
    assign sel.late  = sel_late;

    wpc_phase_ctr u_ctr (
        .clk    (clk),
        .rst    (rst),
        .enable (pc_en),
        .strobe (wd_stb),
        .phase  (phase),
        .start  (start)
    );

    wpc_sel_hold u_sel (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .sel_in  (sel),
        .shift_q (shift_q)
    );

    wpc_out_stage u_out (
        .enable  (pc_en),
        .phase   (phase),
        .shift_q (shift_q),
        .wd_in   (wd_in),
        .wd_out  (wd_out),
        .stb_clr (stb_clr)
    );

    // R8
    pulse_width_chk: assert property (@(posedge clk) disable iff (rst)
        (pc_en && wd_out) |=> (!wd_out || !pc_en));

    // R2
    pulse_in_window_chk: assert property (@(posedge clk) disable iff (rst)
        (pc_en && wd_out) |-> (phase != PH_IDLE && phase != PH_4));

    // R6
    clr_after_p3_chk: assert property (@(posedge clk) disable iff (rst)
        stb_clr |-> ($past(phase) == PH_3));

    // R7
    bypass_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !pc_en |=> (phase == PH_IDLE));

endmodule

// File: tb/test_wprecomp_shifter.sv
module test_wprecomp_shifter;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wd_in = 1'b0, wd_stb = 1'b0, sel_early = 1'b0, sel_late = 1'b0;
    logic inner_trk = 1'b1, dden_n = 1'b0;
    logic wd_out, stb_clr;

    int errs = 0;
    int checks = 0;
    int ref_ph = 0;
    int ref_tgt = 2;
    bit ref_both = 1'b0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    wprecomp_shifter i_wprecomp_shifter (
        .clk(clk), .rst(rst), .wd_in(wd_in), .wd_stb(wd_stb),
        .sel_early(sel_early), .sel_late(sel_late),
        .inner_trk(inner_trk), .dden_n(dden_n),
        .wd_out(wd_out), .stb_clr(stb_clr)
    );

    // Behavioural reference: phase count in integers.
    always @(posedge clk) begin
        if (rst || !(inner_trk && !dden_n)) ref_ph <= 0;
        else if (ref_ph == 0) begin
            if (wd_stb) begin
                ref_ph   <= 1;
                ref_tgt  <= (sel_early && !sel_late) ? 1 : ((sel_late && !sel_early) ? 3 : 2);
                ref_both <= sel_early && sel_late;
            end
        end else ref_ph <= (ref_ph == 4) ? 0 : ref_ph + 1;
    end

    function automatic string auto_tag();
        if (!(inner_trk && !dden_n)) return "R7";
        if (ref_ph == 4) return "R6";
        if (ref_ph == 0) return "R8";
        if (ref_tgt == 1) return "R3";
        if (ref_tgt == 3) return "R4";
        if (ref_both) return "R5";
        return "R2";
    endfunction

    task automatic compare(input string tag);
        logic en, exp_wd, exp_clr;
        string t;
        en = inner_trk && !dden_n;
        exp_wd  = en ? (ref_ph != 0 && ref_ph == ref_tgt) : wd_in;
        exp_clr = en && (ref_ph == 4);
        t = (tag == "") ? auto_tag() : tag;
        checks++;
        if (wd_out !== exp_wd || stb_clr !== exp_clr) begin
            errs++;
            $display("FAIL %s: wd_out=%b stb_clr=%b expected wd_out=%b stb_clr=%b",
                     t, wd_out, stb_clr, exp_wd, exp_clr);
        end
    endtask

    task automatic step(input logic w, input logic s, input logic e, input logic l,
                        input logic it, input logic dn, input string tag);
        @(negedge clk);
        wd_in = w; wd_stb = s; sel_early = e; sel_late = l;
        inner_trk = it; dden_n = dn;
        #1;
        if (!rst) compare(tag);
    endtask

    task automatic pulse(input logic e, input logic l, input string tag);
        step(0, 1, e, l, 1, 0, tag);
        for (int i = 0; i < 5; i++) step(0, 0, e, l, 1, 0, tag);
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            errs++; checks++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        int lfsr;
        for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 1, 0, "");
        rst = 1'b0;
        for (int i = 0; i < 3; i++) step(1, 0, 0, 0, 1, 0, "R1");

        pulse(0, 0, "R2");
        pulse(1, 0, "R3");
        pulse(0, 1, "R4");
        pulse(1, 1, "R5");

        // R9: strobe held high through the whole sequence
        for (int i = 0; i < 12; i++) step(0, 1, 0, 0, 1, 0, "R9");
        for (int i = 0; i < 5; i++) step(0, 0, 0, 0, 1, 0, "R9");

        // R10: selects flip after the strobe is taken
        step(0, 1, 1, 0, 1, 0, "R10");
        for (int i = 0; i < 5; i++) step(0, 0, 0, 1, 1, 0, "R10");
        step(0, 1, 0, 1, 1, 0, "R10");
        for (int i = 0; i < 5; i++) step(0, 0, 1, 0, 1, 0, "R10");

        // R7: bypass on outer tracks, then single density
        for (int i = 0; i < 8; i++) step(i[0], i[1], 0, 0, 0, 0, "R7");
        for (int i = 0; i < 8; i++) step(!i[0], 1, 1, 0, 1, 1, "R7");
        // R7: bypass entered mid-sequence drops to idle
        step(0, 1, 0, 0, 1, 0, "R7");
        step(0, 0, 0, 0, 1, 0, "R7");
        step(1, 0, 0, 0, 0, 0, "R7");
        for (int i = 0; i < 5; i++) step(0, 0, 0, 0, 1, 0, "R7");

        // Mixed pseudo-random traffic
        lfsr = 32'h1ACE5;
        for (int i = 0; i < 3000; i++) begin
            lfsr = (lfsr << 1) ^ (((lfsr >> 31) & 1) != 0 ? 32'h04C11DB7 : 0);
            step(lfsr[3], lfsr[5], lfsr[7], lfsr[9],
                 lfsr[12:11] != 2'b00, lfsr[15:13] == 3'b000, "");
        end

        // Reset in the middle of a sequence
        step(0, 1, 0, 1, 1, 0, "R1");
        step(0, 0, 0, 1, 1, 0, "R1");
        rst = 1'b1;
        step(0, 0, 0, 0, 1, 0, "R1");
        rst = 1'b0;
        for (int i = 0; i < 4; i++) step(0, 0, 0, 0, 1, 0, "R1");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule